// File: doc/BRIEF.md
# Compression Header Guard

This block sits beside a fronthaul IQ compression datapath and vets the per-packet compression header in both directions. Every header carries a 4-bit sample-width code and a 4-bit method code. The block takes the pair either from the packet or from a software-programmed static value. It checks the width against a build-time mask of supported widths, and the method against the methods enabled at build time. One cycle later it returns a corrected header together with a drop flag.

The two directions repair faults in opposite ways. On transmit, a bad width is forced to the 16-bit code and the packet passes, while a bad method drops the packet. On receive, a bad width drops the packet, while a bad method is replaced by an enabled default method. Every fault sets a sticky error bit that software clears by writing one. A small word-addressed register port holds the mode register and the two error registers.

Top module: `fhc_hdr_guard`

## Requirements
- R1: Word address 0 holds the mode register. Bit 8 is the header source, bits 7:4 are the static width code and bits 3:0 are the static method code. Bits 31:9 read as zero and ignore writes. All fields and both error registers reset to zero.
- R2: With mode bit 8 at 0, both directions check the static code from mode bits 7:0 and ignore the packet's codes. With bit 8 at 1, they check the packet's codes.
- R3: A method code is legal only if it is 0000 (uncompressed), 0001 (block floating point, when `BFP_EN` is set) or 0011 (µ-law, when `MULAW_EN` is set). Every other code is illegal.
- R4: A width code is legal when bit `code` of `WIDTH_MASK` is set. Code 0000 means 16 bits and code N means N bits. The default mask accepts 0000 and 1000 through 1111.
- R5: Transmit with an illegal width: the output width becomes 0000, the packet is not dropped on that account, and transmit error bit 1 (address 1) is set.
- R6: Transmit with an illegal method: the drop flag is raised, the method is passed on unchanged, and transmit error bit 0 is set.
- R7: Receive with an illegal width: the drop flag is raised, the width is passed on unchanged, and receive error bit 1 (address 2) is set.
- R8: Receive with an illegal method: the method is replaced by 0001 when block floating point is enabled, otherwise by 0011, and receive error bit 0 is set.
- R9: The output valid goes high exactly one cycle after a header strobe, carrying the corrected header. It is low in every other cycle.
- R10: Error bits stay set until software writes 1 to them. When a fault and a clear hit the same bit in the same cycle, the bit stays set.
- R11: Reads of addresses other than 0, 1 and 2 return zero, and writes to them change nothing.
- R12: A header with a legal width and a legal method passes unchanged, is not dropped, and sets no error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | ADDR_W | Register word address |
| csr_wdata | input | DATA_W | Register write data |
| csr_rdata | output | DATA_W | Register read data for `csr_addr` (combinational) |
| tx_hdr_vld | input | 1 | Transmit header strobe |
| tx_hdr_width | input | 4 | Transmit packet width code |
| tx_hdr_meth | input | 4 | Transmit packet method code |
| tx_out_vld | output | 1 | Transmit result valid |
| tx_out_width | output | 4 | Corrected transmit width code |
| tx_out_meth | output | 4 | Transmit method code |
| tx_out_drop | output | 1 | Drop the transmit packet |
| rx_hdr_vld | input | 1 | Receive header strobe |
| rx_hdr_width | input | 4 | Receive packet width code |
| rx_hdr_meth | input | 4 | Receive packet method code |
| rx_out_vld | output | 1 | Receive result valid |
| rx_out_width | output | 4 | Receive width code |
| rx_out_meth | output | 4 | Corrected receive method code |
| rx_out_drop | output | 1 | Drop the receive packet |

## Verification
The assertions assume that `WIDTH_MASK` accepts code 0000 and that at least one compressing method is enabled. With those two facts, every forced transmit width and every substituted receive method is legal. They also assume header strobes and register writes are single-cycle pulses sampled at the clock edge. The stimulus changes inputs only on the falling edge and leaves the header strobes low between headers. A second instance built with µ-law only covers the alternate receive default within the same assumptions.

// File: rtl/fhc_pkg.sv
package fhc_pkg;

   localparam logic [3:0] METH_NONE  = 4'b0000;
   localparam logic [3:0] METH_BFP   = 4'b0001;
   localparam logic [3:0] METH_MULAW = 4'b0011;
   localparam logic [3:0] WIDTH_16   = 4'b0000;

   localparam int unsigned ADDR_MODE  = 0;
   localparam int unsigned ADDR_TXERR = 1;
   localparam int unsigned ADDR_RXERR = 2;

   localparam int unsigned MODE_W = 9;
   localparam int unsigned ERR_W  = 2;

   typedef struct packed {
      logic [3:0] width;
      logic [3:0] meth;
   } hdr_t;

   typedef struct packed {
      logic dyn;
      hdr_t stat;
   } mode_t;

   function automatic logic meth_ok(input logic [3:0] m, input bit bfp_en, input bit mu_en);
      case (m)
         METH_NONE:  meth_ok = 1'b1;
         METH_BFP:   meth_ok = bfp_en;
         METH_MULAW: meth_ok = mu_en;
         default:    meth_ok = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/fhc_sticky.sv
module fhc_sticky #(
   parameter int unsigned W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic [W-1:0] clr,
   output logic [W-1:0] q
);
   // a hardware set overrides a clear in the same cycle
   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= (q & ~clr) | set;
   end
endmodule

// File: rtl/fhc_hdr_check.sv
module fhc_hdr_check
   import fhc_pkg::*;
#(
   parameter bit          IS_RX      = 1'b0,
   parameter bit          BFP_EN     = 1'b1,
   parameter bit          MULAW_EN   = 1'b1,
   parameter logic [15:0] WIDTH_MASK = 16'hFF01
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_vld,
   input  hdr_t in_hdr,
   output logic out_vld,
   output hdr_t out_hdr,
   output logic out_drop,
   output logic evt_width,
   output logic evt_meth
);
   localparam logic [3:0] DFLT_METH = BFP_EN ? METH_BFP : METH_MULAW;

   logic w_ok, m_ok, drop_n;
   hdr_t hdr_n;

   assign w_ok = WIDTH_MASK[in_hdr.width];
   assign m_ok = meth_ok(in_hdr.meth, BFP_EN, MULAW_EN);

   generate
      if (IS_RX) begin : g_rx
         always_comb begin
            drop_n       = ~w_ok;
            hdr_n.width  = in_hdr.width;
            hdr_n.meth   = m_ok ? in_hdr.meth : DFLT_METH;
         end
      end else begin : g_tx
         always_comb begin
            drop_n       = ~m_ok;
            hdr_n.width  = w_ok ? in_hdr.width : WIDTH_16;
            hdr_n.meth   = in_hdr.meth;
         end
      end
   endgenerate

   assign evt_width = in_vld & ~w_ok;
   assign evt_meth  = in_vld & ~m_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_hdr  <= '0;
         out_drop <= 1'b0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) begin
            out_hdr  <= hdr_n;
            out_drop <= drop_n;
         end
      end
   end
endmodule

// File: rtl/fhc_csr.sv
module fhc_csr
   import fhc_pkg::*;
#(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [ERR_W-1:0]  tx_err,
   input  logic [ERR_W-1:0]  rx_err,
   output mode_t             mode,
   output logic [ERR_W-1:0]  tx_clr,
   output logic [ERR_W-1:0]  rx_clr
);
   logic sel_mode, sel_tx, sel_rx;

   assign sel_mode = (addr == ADDR_W'(ADDR_MODE));
   assign sel_tx   = (addr == ADDR_W'(ADDR_TXERR));
   assign sel_rx   = (addr == ADDR_W'(ADDR_RXERR));

   wire unused_wdata = ^wdata[DATA_W-1:MODE_W];

   always_ff @(posedge clk) begin
      if (!rst_n)              mode <= '0;
      else if (wr && sel_mode) mode <= mode_t'(wdata[MODE_W-1:0]);
   end

   assign tx_clr = (wr && sel_tx) ? wdata[ERR_W-1:0] : '0;
   assign rx_clr = (wr && sel_rx) ? wdata[ERR_W-1:0] : '0;

   always_comb begin
      rdata = '0;
      if (sel_mode)    rdata[MODE_W-1:0] = mode;
      else if (sel_tx) rdata[ERR_W-1:0]  = tx_err;
      else if (sel_rx) rdata[ERR_W-1:0]  = rx_err;
   end
endmodule

// File: rtl/fhc_hdr_guard.sv
module fhc_hdr_guard
   import fhc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned DATA_W     = 32,
   parameter bit          BFP_EN     = 1'b1,
   parameter bit          MULAW_EN   = 1'b1,
   parameter logic [15:0] WIDTH_MASK = 16'hFF01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_wr,
   input  logic [ADDR_W-1:0] csr_addr,
   input  logic [DATA_W-1:0] csr_wdata,
   output logic [DATA_W-1:0] csr_rdata,
   input  logic              tx_hdr_vld,
   input  logic [3:0]        tx_hdr_width,
   input  logic [3:0]        tx_hdr_meth,
   output logic              tx_out_vld,
   output logic [3:0]        tx_out_width,
   output logic [3:0]        tx_out_meth,
   output logic              tx_out_drop,
   input  logic              rx_hdr_vld,
   input  logic [3:0]        rx_hdr_width,
   input  logic [3:0]        rx_hdr_meth,
   output logic              rx_out_vld,
   output logic [3:0]        rx_out_width,
   output logic [3:0]        rx_out_meth,
   output logic              rx_out_drop
);
   localparam int unsigned NDIR = 2;

   if (DATA_W < MODE_W)          $error("DATA_W too narrow for the mode register");
   if (ADDR_W < 2)               $error("ADDR_W cannot reach three registers");
   if (!(BFP_EN || MULAW_EN))    $error("receive default needs an enabled method");
   if (!WIDTH_MASK[0])           $error("transmit fallback width 16 must be supported");

   mode_t            mode_q;
   logic [ERR_W-1:0] tx_err_q, rx_err_q, tx_clr, rx_clr;

   fhc_csr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_csr (
      .clk(clk), .rst_n(rst_n), .wr(csr_wr), .addr(csr_addr), .wdata(csr_wdata),
      .rdata(csr_rdata), .tx_err(tx_err_q), .rx_err(rx_err_q),
      .mode(mode_q), .tx_clr(tx_clr), .rx_clr(rx_clr)
   );

   logic [NDIR-1:0] vld_in, vld_out, drop_out, ev_w, ev_m;
   hdr_t            hdr_pkt [NDIR];
   hdr_t            hdr_in  [NDIR];
   hdr_t            hdr_out [NDIR];

   assign vld_in  = {rx_hdr_vld, tx_hdr_vld};
   assign hdr_pkt[0] = '{width: tx_hdr_width, meth: tx_hdr_meth};
   assign hdr_pkt[1] = '{width: rx_hdr_width, meth: rx_hdr_meth};

   for (genvar d = 0; d < NDIR; d++) begin : g_dir
      assign hdr_in[d] = mode_q.dyn ? hdr_pkt[d] : mode_q.stat;
      fhc_hdr_check #(
         .IS_RX(d == 1), .BFP_EN(BFP_EN), .MULAW_EN(MULAW_EN), .WIDTH_MASK(WIDTH_MASK)
      ) u_chk (
         .clk(clk), .rst_n(rst_n), .in_vld(vld_in[d]), .in_hdr(hdr_in[d]),
         .out_vld(vld_out[d]), .out_hdr(hdr_out[d]), .out_drop(drop_out[d]),
         .evt_width(ev_w[d]), .evt_meth(ev_m[d])
      );
   end

   fhc_sticky #(.W(ERR_W)) u_tx_err (
      .clk(clk), .rst_n(rst_n), .set({ev_w[0], ev_m[0]}), .clr(tx_clr), .q(tx_err_q)
   );
   fhc_sticky #(.W(ERR_W)) u_rx_err (
      .clk(clk), .rst_n(rst_n), .set({ev_w[1], ev_m[1]}), .clr(rx_clr), .q(rx_err_q)
   );

   assign tx_out_vld   = vld_out[0];
   assign tx_out_width = hdr_out[0].width;
   assign tx_out_meth  = hdr_out[0].meth;
   assign tx_out_drop  = drop_out[0];
   assign rx_out_vld   = vld_out[1];
   assign rx_out_width = hdr_out[1].width;
   assign rx_out_meth  = hdr_out[1].meth;
   assign rx_out_drop  = drop_out[1];
endmodule

// File: rtl/fhc_hdr_guard_chk.sv
module fhc_hdr_guard_chk
   import fhc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned DATA_W     = 32,
   parameter bit          BFP_EN     = 1'b1,
   parameter bit          MULAW_EN   = 1'b1,
   parameter logic [15:0] WIDTH_MASK = 16'hFF01
) (
   input logic              clk,
   input logic              rst_n,
   input logic              csr_wr,
   input logic [ADDR_W-1:0] csr_addr,
   input logic [DATA_W-1:0] csr_wdata,
   input logic [DATA_W-1:0] csr_rdata,
   input logic              tx_hdr_vld,
   input logic              tx_out_vld,
   input logic [3:0]        tx_out_width,
   input logic [3:0]        tx_out_meth,
   input logic              tx_out_drop,
   input logic              rx_hdr_vld,
   input logic              rx_out_vld,
   input logic [3:0]        rx_out_width,
   input logic [3:0]        rx_out_meth,
   input logic              rx_out_drop,
   input logic [ERR_W-1:0]  tx_err_q
);
   p_mode_rsv_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_addr == ADDR_W'(ADDR_MODE)) |-> (csr_rdata[DATA_W-1:MODE_W] == '0));

   p_tx_width_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_out_vld |-> WIDTH_MASK[tx_out_width]);

   p_tx_pass_meth_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_out_vld && !tx_out_drop) |-> meth_ok(tx_out_meth, BFP_EN, MULAW_EN));

   p_rx_pass_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_out_vld && !rx_out_drop) |-> WIDTH_MASK[rx_out_width]);

   p_rx_meth_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_out_vld |-> meth_ok(rx_out_meth, BFP_EN, MULAW_EN));

   p_tx_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_hdr_vld |=> tx_out_vld);

   p_tx_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_hdr_vld |=> !tx_out_vld);

   p_rx_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_hdr_vld |=> rx_out_vld);

   p_tx_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_err_q[0] && !(csr_wr && csr_addr == ADDR_W'(ADDR_TXERR) && csr_wdata[0]))
      |=> tx_err_q[0]);

   p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_addr > ADDR_W'(ADDR_RXERR)) |-> (csr_rdata == '0));
endmodule

bind fhc_hdr_guard fhc_hdr_guard_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BFP_EN(BFP_EN),
   .MULAW_EN(MULAW_EN), .WIDTH_MASK(WIDTH_MASK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
   .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
   .tx_hdr_vld(tx_hdr_vld), .tx_out_vld(tx_out_vld), .tx_out_width(tx_out_width),
   .tx_out_meth(tx_out_meth), .tx_out_drop(tx_out_drop),
   .rx_hdr_vld(rx_hdr_vld), .rx_out_vld(rx_out_vld), .rx_out_width(rx_out_width),
   .rx_out_meth(rx_out_meth), .rx_out_drop(rx_out_drop),
   .tx_err_q(tx_err_q)
);

// File: tb/fhc_hdr_guard_bench.sv
module fhc_hdr_guard_bench;
   typedef struct packed {
      logic [3:0] w;   logic [3:0] m;
      logic [3:0] txw; logic [3:0] txm; logic txd;
      logic [3:0] rxw; logic [3:0] rxm; logic rxd;
      logic [1:0] txe; logic [1:0] rxe;
   } vec_t;

   // default build: both methods on, widths 0000 and 1000..1111 legal
   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{4'd0,  4'd1,  4'd0,  4'd1,  1'b0, 4'd0,  4'd1, 1'b0, 2'b00, 2'b00}, // R12
      '{4'd9,  4'd3,  4'd9,  4'd3,  1'b0, 4'd9,  4'd3, 1'b0, 2'b00, 2'b00}, // R12
      '{4'd0,  4'd0,  4'd0,  4'd0,  1'b0, 4'd0,  4'd0, 1'b0, 2'b00, 2'b00}, // R3
      '{4'd5,  4'd1,  4'd0,  4'd1,  1'b0, 4'd5,  4'd1, 1'b1, 2'b10, 2'b10}, // R5 R7
      '{4'd8,  4'd2,  4'd8,  4'd2,  1'b1, 4'd8,  4'd1, 1'b0, 2'b01, 2'b01}, // R6 R8
      '{4'd3,  4'd7,  4'd0,  4'd7,  1'b1, 4'd3,  4'd1, 1'b1, 2'b11, 2'b11}, // R4
      '{4'd15, 4'd15, 4'd15, 4'd15, 1'b1, 4'd15, 4'd1, 1'b0, 2'b01, 2'b01}, // R3
      '{4'd1,  4'd3,  4'd0,  4'd3,  1'b0, 4'd1,  4'd3, 1'b1, 2'b10, 2'b10}  // R4
   };

   logic        clk = 1'b0, rst_n = 1'b0, csr_wr = 1'b0;
   logic [3:0]  csr_addr = '0;
   logic [31:0] csr_wdata = '0, rdata, rdata_mu;
   logic        tx_vld = 1'b0, rx_vld = 1'b0;
   logic [3:0]  tx_w = '0, tx_m = '0, rx_w = '0, rx_m = '0;
   logic        tx_ov, tx_od, rx_ov, rx_od, mtx_ov, mtx_od, mrx_ov, mrx_od;
   logic [3:0]  tx_ow, tx_om, rx_ow, rx_om, mtx_ow, mtx_om, mrx_ow, mrx_om;
   int          errors = 0, checks = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   fhc_hdr_guard u_fhc_hdr_guard (
      .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(rdata),
      .tx_hdr_vld(tx_vld), .tx_hdr_width(tx_w), .tx_hdr_meth(tx_m),
      .tx_out_vld(tx_ov), .tx_out_width(tx_ow), .tx_out_meth(tx_om), .tx_out_drop(tx_od),
      .rx_hdr_vld(rx_vld), .rx_hdr_width(rx_w), .rx_hdr_meth(rx_m),
      .rx_out_vld(rx_ov), .rx_out_width(rx_ow), .rx_out_meth(rx_om), .rx_out_drop(rx_od)
   );

   fhc_hdr_guard #(.BFP_EN(1'b0), .MULAW_EN(1'b1)) u_mu (
      .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(rdata_mu),
      .tx_hdr_vld(tx_vld), .tx_hdr_width(tx_w), .tx_hdr_meth(tx_m),
      .tx_out_vld(mtx_ov), .tx_out_width(mtx_ow), .tx_out_meth(mtx_om), .tx_out_drop(mtx_od),
      .rx_hdr_vld(rx_vld), .rx_hdr_width(rx_w), .rx_hdr_meth(rx_m),
      .rx_out_vld(mrx_ov), .rx_out_width(mrx_ow), .rx_out_meth(mrx_om), .rx_out_drop(mrx_od)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
      @(negedge clk);
      csr_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      csr_addr = a; #1; d = rdata;
   endtask

   // strobe one header on both directions; returns at the negedge where outputs are valid
   task automatic hdr(input logic [3:0] w, input logic [3:0] m);
      @(negedge clk);
      tx_vld = 1'b1; rx_vld = 1'b1; tx_w = w; tx_m = m; rx_w = w; rx_m = m;
      @(negedge clk);
      tx_vld = 1'b0; rx_vld = 1'b0;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(20 * 100000);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // reset state, R1 R10
      check("R9", "tx/rx valid after reset", {tx_ov, rx_ov}, 0);
      rd(4'd0, d); check("R1", "mode after reset", d, 0);
      rd(4'd1, d); check("R10", "tx errors after reset", d, 0);
      rd(4'd2, d); check("R10", "rx errors after reset", d, 0);

      // R1: reserved bits ignore writes
      wr(4'd0, 32'hFFFF_FF93);
      rd(4'd0, d); check("R1", "mode readback", d, 32'h193);

      // vector table in dynamic mode, R3..R8 R12
      wr(4'd0, 32'h100);
      for (int i = 0; i < NV; i++) begin
         wr(4'd1, 32'h3); wr(4'd2, 32'h3);
         hdr(VECS[i].w, VECS[i].m);
         check("R5 R6", $sformatf("tx out vec%0d", i), {tx_ov, tx_ow, tx_om, tx_od},
               {1'b1, VECS[i].txw, VECS[i].txm, VECS[i].txd});
         check("R7 R8", $sformatf("rx out vec%0d", i), {rx_ov, rx_ow, rx_om, rx_od},
               {1'b1, VECS[i].rxw, VECS[i].rxm, VECS[i].rxd});
         rd(4'd1, d); check("R10", $sformatf("tx err vec%0d", i), d, {30'd0, VECS[i].txe});
         rd(4'd2, d); check("R10", $sformatf("rx err vec%0d", i), d, {30'd0, VECS[i].rxe});
      end

      // R9: valid drops one cycle later
      @(negedge clk);
      check("R9", "valid low after result", {tx_ov, rx_ov}, 0);

      // R8: µ-law-only build substitutes 0011, drops tx block floating point
      wr(4'd1, 32'h3); wr(4'd2, 32'h3);
      hdr(4'd0, 4'd1);
      check("R8", "mu rx out", {mrx_ov, mrx_ow, mrx_om, mrx_od}, {1'b1, 4'd0, 4'd3, 1'b0});
      check("R6", "mu tx out", {mtx_ov, mtx_ow, mtx_om, mtx_od}, {1'b1, 4'd0, 4'd1, 1'b1});
      csr_addr = 4'd1; #1; check("R6", "mu tx err", rdata_mu, 1);

      // R2: static header 5/0011 replaces packet 0/0001
      wr(4'd0, 32'h053);
      wr(4'd1, 32'h3); wr(4'd2, 32'h3);
      hdr(4'd0, 4'd1);
      check("R2", "static tx out", {tx_ow, tx_om, tx_od}, {4'd0, 4'd3, 1'b0});
      check("R2", "static rx out", {rx_ow, rx_om, rx_od}, {4'd5, 4'd3, 1'b1});
      wr(4'd0, 32'h100);

      // R11: unmapped address
      wr(4'd5, 32'hFFFF_FFFF);
      rd(4'd5, d); check("R11", "unmapped read", d, 0);
      rd(4'd0, d); check("R11", "mode after unmapped write", d, 32'h100);

      // R10: set beats clear in the same cycle
      wr(4'd1, 32'h3);
      hdr(4'd5, 4'd1);
      rd(4'd1, d); check("R10", "tx width error set", d, 2);
      hdr(4'd0, 4'd1);
      rd(4'd1, d); check("R10", "sticky across clean header", d, 2);
      @(negedge clk);
      csr_wr = 1'b1; csr_addr = 4'd1; csr_wdata = 32'h3;
      tx_vld = 1'b1; tx_w = 4'd8; tx_m = 4'd2;
      @(negedge clk);
      csr_wr = 1'b0; tx_vld = 1'b0;
      rd(4'd1, d); check("R10", "set wins over clear", d, 1);
      wr(4'd1, 32'h1);
      rd(4'd1, d); check("R10", "cleared by write one", d, 0);

      summary();
   end
endmodule